// File: doc/BRIEF.md
# Two-Channel I2C Bus Switch Controller

This block is the digital core of an I2C-controlled bus switch. It watches SCL and SDA as an I2C slave. It answers to a seven-bit address made of a fixed five-bit prefix and two strap inputs, and it keeps a control byte. Bits 0 and 1 of that byte choose which of two downstream bus segments are connected. A new selection reaches the channel enable outputs only when the master ends the transaction with a STOP, so a segment is never switched in halfway through a transfer.

Reading the block returns a status byte. Its low bits hold the selection most recently written. Bits 4 and 5 show the live state of the per-channel interrupt inputs, captured as each byte is loaded for transmit. An interrupt output pin is pulled low whenever either interrupt input is active, whether or not that channel is enabled. An active-low reset pin and a power-on reset input each bring the block back to all zeroes.

Top module: `i2c_chsel_switch`

## Requirements
- R1: While either reset input is low, and after it is released, ch_en reads 0, sda_oe reads 0 and the selection reads back as 0.
- R2: An address byte equal to {ADDR_PREFIX, addr_sel} (default prefix 5'b11100, address in bits 7:1) is acknowledged with SDA low in the ninth clock. Any other address gets no acknowledge, and all following bytes are ignored without acknowledge until the next START or STOP.
- R3: Each data byte of a write is acknowledged and replaces the selection. When several bytes arrive in one transaction, the last complete byte is the one kept.
- R4: ch_en changes only on a STOP, taking the selection held at that moment. A repeated START does not update it.
- R5: Bit 0 of the written byte enables channel 0 and bit 1 enables channel 1. Both may be enabled together.
- R6: A read returns the current selection in bits 1:0 and the active states of the interrupt inputs in bits 4 (channel 0) and 5 (channel 1), sent most significant bit first. The selection read is the one last written, even before the STOP that commits it.
- R7: The interrupt bits are captured each time a read byte is loaded: at the end of the address acknowledge, and again after each master acknowledge.
- R8: irq_oe is 1 (output driven low) whenever any irq_n input is low, regardless of ch_en, including when both inputs are low.
- R9: During a read, a master not-acknowledge (SDA high in the ninth clock) ends transmission, and the block releases SDA.
- R10: Bits 2, 3, 6 and 7 of a written byte have no effect, and bits 2, 3, 6 and 7 of every read byte are 0.
- R11: A byte cut short by a STOP before its eighth bit does not change the selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| por_n | input | 1 | Power-on reset, active low |
| rst_n | input | 1 | External reset pin, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_sel | input | 2 | Strap inputs for the two low address bits |
| irq_n | input | NUM_CH | Per-channel interrupt inputs, active low |
| irq_oe | output | 1 | 1 pulls the interrupt output low |
| ch_en | output | NUM_CH | Committed channel enables |

## Verification
The bench goes after the timing of the commit. It writes a selection, then runs a repeated START followed by a read, and expects the new value to be read back while ch_en still holds the old one. A design that commits on every write, or on any START, switches the segment early. A STOP placed halfway through a byte must leave the selection alone, and a design that stores partial bytes would change it. Interrupt inputs are changed between the first and second bytes of one read, so a design that captures the status only once per transaction returns a stale second byte. The bench also checks that an unmatched address is followed by silence, which a design that resumed decoding mid-transaction would break by acknowledging later bytes.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_SKIP
   } bus_state_t;
   localparam int BYTE_W   = 8;
   localparam int IRQ_LSB  = 4;
   localparam int DEV_A_W  = 7;
endpackage

// File: rtl/chsel_sync.sv
module chsel_sync #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("chsel_sync needs at least two stages");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= {W{RST_VAL}};
         else if (s == 0) chain[s] <= d;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/chsel_busmon.sv
module chsel_busmon (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic start_evt,
   output logic stop_evt,
   output logic scl_rise,
   output logic scl_fall
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
endmodule

// File: rtl/chsel_engine.sv
module chsel_engine
   import chsel_pkg::*;
#(
   parameter int PFX_W = 5,
   parameter logic [PFX_W-1:0] ADDR_PREFIX = 5'b11100,
   localparam int HW_W = DEV_A_W - PFX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_evt,
   input  logic              stop_evt,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_s,
   input  logic [HW_W-1:0]   hw_addr,
   input  logic [BYTE_W-1:0] status,
   output logic              sda_oe,
   output logic              wr_stb,
   output logic [BYTE_W-1:0] wr_byte
);
   if (PFX_W < 1 || PFX_W >= DEV_A_W) begin : g_bad_pfx
      $error("prefix width must leave room for strap bits");
   end

   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

   bus_state_t        state;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] sh, tx;
   logic              rd_op, m_nack;
   logic [DEV_A_W-1:0] dev_addr;

   assign dev_addr = {ADDR_PREFIX, hw_addr};
   assign wr_byte  = sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         sh     <= '0;
         tx     <= '0;
         sda_oe <= 1'b0;
         rd_op  <= 1'b0;
         m_nack <= 1'b0;
         wr_stb <= 1'b0;
      end else begin
         wr_stb <= 1'b0;
         if (stop_evt) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else if (start_evt) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_ADDR: begin
                  if (scl_rise) begin
                     sh  <= {sh[BYTE_W-2:0], sda_s};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == FULL) begin
                     if (sh[BYTE_W-1:1] == dev_addr) begin
                        sda_oe <= 1'b1;
                        rd_op  <= sh[0];
                        state  <= ST_ADDR_ACK;
                     end else begin
                        state  <= ST_SKIP;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (rd_op) begin
                        tx     <= status;
                        sda_oe <= ~status[BYTE_W-1];
                        state  <= ST_RD;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_WR;
                     end
                  end
               end
               ST_WR: begin
                  if (scl_rise) begin
                     sh  <= {sh[BYTE_W-2:0], sda_s};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == FULL) begin
                     wr_stb <= 1'b1;
                     sda_oe <= 1'b1;
                     state  <= ST_WR_ACK;
                  end
               end
               ST_WR_ACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                     state  <= ST_WR;
                  end
               end
               ST_RD: begin
                  if (scl_fall) begin
                     if (cnt == LAST) begin
                        sda_oe <= 1'b0;
                        state  <= ST_RD_ACK;
                     end else begin
                        tx     <= {tx[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~tx[BYTE_W-2];
                        cnt    <= cnt + 1'b1;
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) begin
                     m_nack <= sda_s;
                  end else if (scl_fall) begin
                     if (m_nack) begin
                        state <= ST_SKIP;
                     end else begin
                        tx     <= status;
                        sda_oe <= ~status[BYTE_W-1];
                        cnt    <= '0;
                        state  <= ST_RD;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R2
   skip_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |-> !sda_oe);

   // R9
   master_ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RD_ACK) |-> !sda_oe);
endmodule

// File: rtl/chsel_irq.sv
module chsel_irq #(
   parameter int NUM_CH = 2,
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] irq_s,
   output logic [NUM_CH-1:0] irq_act,
   output logic              irq_oe
);
   if (ACTIVE_LOW) begin : g_low
      assign irq_act = ~irq_s;
   end else begin : g_high
      assign irq_act = irq_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_oe <= 1'b0;
      else irq_oe <= |irq_act;
   end

   // R8
   irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_act) |=> irq_oe);

   // R8
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|irq_act) |=> !irq_oe);
endmodule

// File: rtl/i2c_chsel_switch.sv
module i2c_chsel_switch
   import chsel_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int SYNC_STAGES = 2,
   parameter logic [4:0] ADDR_PREFIX = 5'b11100,
   parameter bit IRQ_ACTIVE_LOW = 1'b1,
   localparam int PFX_W = 5,
   localparam int HW_W = DEV_A_W - PFX_W
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [HW_W-1:0]   addr_sel,
   input  logic [NUM_CH-1:0] irq_n,
   output logic              irq_oe,
   output logic [NUM_CH-1:0] ch_en
);
   if (NUM_CH < 1 || NUM_CH > IRQ_LSB) begin : g_bad_ch
      $error("NUM_CH must fit below the interrupt field");
   end

   logic              rst_all;
   logic              scl_s, sda_s;
   logic [NUM_CH-1:0] irq_s, irq_act;
   logic              start_evt, stop_evt, scl_rise, scl_fall;
   logic              wr_stb;
   logic [BYTE_W-1:0] wr_byte, status;
   logic [NUM_CH-1:0] sel_q;

   assign rst_all = por_n & rst_n;

   chsel_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_bus_sync (
      .clk(clk), .rst_n(rst_all), .d({scl_i, sda_i}), .q({scl_s, sda_s}));

   chsel_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES), .RST_VAL(IRQ_ACTIVE_LOW)) u_irq_sync (
      .clk(clk), .rst_n(rst_all), .d(irq_n), .q(irq_s));

   chsel_busmon u_mon (
      .clk(clk), .rst_n(rst_all), .scl_s(scl_s), .sda_s(sda_s),
      .start_evt(start_evt), .stop_evt(stop_evt),
      .scl_rise(scl_rise), .scl_fall(scl_fall));

   chsel_engine #(.PFX_W(PFX_W), .ADDR_PREFIX(ADDR_PREFIX)) u_eng (
      .clk(clk), .rst_n(rst_all), .start_evt(start_evt), .stop_evt(stop_evt),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
      .hw_addr(addr_sel), .status(status), .sda_oe(sda_oe),
      .wr_stb(wr_stb), .wr_byte(wr_byte));

   chsel_irq #(.NUM_CH(NUM_CH), .ACTIVE_LOW(IRQ_ACTIVE_LOW)) u_irq (
      .clk(clk), .rst_n(rst_all), .irq_s(irq_s),
      .irq_act(irq_act), .irq_oe(irq_oe));

   always_comb begin
      status = '0;
      status[NUM_CH-1:0] = sel_q;
      status[IRQ_LSB +: NUM_CH] = irq_act;
   end

   always_ff @(posedge clk or negedge rst_all) begin
      if (!rst_all) begin
         sel_q <= '0;
         ch_en <= '0;
      end else begin
         if (wr_stb) sel_q <= wr_byte[NUM_CH-1:0];
         if (stop_evt) ch_en <= sel_q;
      end
   end

   // R3
   sel_by_write_chk: assert property (@(posedge clk) disable iff (!rst_all)
      !$stable(sel_q) |-> $past(wr_stb));

   // R4
   commit_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_all)
      !$stable(ch_en) |-> $past(stop_evt));
endmodule

// File: tb/i2c_chsel_switch_test.sv
`timescale 1ns/1ps
module i2c_chsel_switch_test;
   localparam int Q = 8;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic por_n = 1'b0, rst_n = 1'b1;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic [1:0] addr_sel = 2'b01;
   logic [1:0] irq_n = 2'b11;
   logic sda_oe, irq_oe;
   logic [1:0] ch_en;
   logic sda_line;

   assign sda_line = sda_m & ~sda_oe;

   i2c_chsel_switch uut (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .addr_sel(addr_sel), .irq_n(irq_n), .irq_oe(irq_oe),
      .ch_en(ch_en));

   int checks = 0, fails = 0;
   logic [1:0] exp_sel = 2'b00, exp_en = 2'b00;
   logic exp_irq = 1'b0;
   bit cmp_en = 1'b0, done = 1'b0;
   int cyc = 0;

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_en && !done) begin
         chk("R4 ch_en per-cycle", {6'b0, ch_en}, {6'b0, exp_en});
         chk("R8 irq_oe per-cycle", {7'b0, irq_oe}, {7'b0, exp_irq});
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000 && !done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_out(input logic b);
      sda_m = b; wt(Q); scl_m = 1'b1; wt(2*Q); scl_m = 1'b0; wt(Q);
   endtask

   task automatic do_start();
      sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
   endtask

   task automatic do_stop();
      sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q);
      cmp_en = 1'b0; sda_m = 1'b1; wt(Q);
      exp_en = exp_sel; cmp_en = 1'b1; wt(Q);
   endtask

   task automatic wr_byte(input logic [7:0] b, input logic exp_ack, input string tag);
      logic ack;
      for (int i = 7; i >= 0; i--) bit_out(b[i]);
      sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q);
      ack = ~sda_line;
      wt(Q); scl_m = 1'b0; wt(Q);
      chk(tag, {7'b0, ack}, {7'b0, exp_ack});
   endtask

   task automatic rd_byte(input logic m_ack, input logic [7:0] exp, input string tag);
      logic [7:0] got;
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wt(Q); scl_m = 1'b1; wt(Q); got[i] = sda_line; wt(Q); scl_m = 1'b0; wt(Q);
      end
      chk(tag, got, exp);
      bit_out(~m_ack);
      sda_m = 1'b1;
   endtask

   task automatic set_irq(input logic [1:0] v);
      cmp_en = 1'b0; irq_n = v; wt(6); exp_irq = ~&v; cmp_en = 1'b1;
   endtask

   task automatic pulse_reset(input bit use_por);
      cmp_en = 1'b0;
      if (use_por) por_n = 1'b0; else rst_n = 1'b0;
      wt(4);
      exp_sel = 2'b00; exp_en = 2'b00;
      chk("R1 ch_en in reset", {6'b0, ch_en}, 8'h00);
      chk("R1 sda_oe in reset", {7'b0, sda_oe}, 8'h00);
      por_n = 1'b1; rst_n = 1'b1; wt(4);
      cmp_en = 1'b1;
   endtask

   task automatic read_status(input logic [7:0] exp, input string tag);
      do_start();
      wr_byte(8'hE3, 1'b1, "R2 read address ack");
      rd_byte(1'b0, exp, tag);
      chk("R9 released after nack", {7'b0, sda_oe}, 8'h00);
      do_stop();
   endtask

   initial begin
      wt(3);
      pulse_reset(1'b1);
      chk("R1 irq_oe after reset", {7'b0, irq_oe}, 8'h00);
      read_status(8'h00, "R1 status after power-on");

      do_start();
      wr_byte(8'hE2, 1'b1, "R2 write address ack");
      wr_byte(8'h01, 1'b1, "R3 data ack");
      exp_sel = 2'b01;
      chk("R4 no commit before stop", {6'b0, ch_en}, 8'h00);
      do_stop();
      chk("R4 commit at stop", {6'b0, ch_en}, 8'h01);

      do_start();
      wr_byte(8'hE2, 1'b1, "R2 write address ack");
      wr_byte(8'h03, 1'b1, "R3 first byte ack");
      wr_byte(8'h00, 1'b1, "R3 second byte ack");
      wr_byte(8'h02, 1'b1, "R3 last byte ack");
      exp_sel = 2'b10;
      do_stop();
      chk("R3 last byte kept", {6'b0, ch_en}, 8'h02);

      do_start();
      wr_byte(8'hE2, 1'b1, "R2 write address ack");
      wr_byte(8'hFF, 1'b1, "R10 data ack");
      exp_sel = 2'b11;
      do_stop();
      chk("R5 both channels enabled", {6'b0, ch_en}, 8'h03);
      read_status(8'h03, "R10 unused bits read zero");

      set_irq(2'b10);
      chk("R8 irq from channel 0", {7'b0, irq_oe}, 8'h01);
      do_start();
      wr_byte(8'hE3, 1'b1, "R2 read address ack");
      set_irq(2'b00);
      rd_byte(1'b1, 8'h13, "R7 first byte captured at load");
      rd_byte(1'b0, 8'h33, "R7 second byte recaptured");
      chk("R9 released after nack", {7'b0, sda_oe}, 8'h00);
      do_stop();
      chk("R8 both interrupts", {7'b0, irq_oe}, 8'h01);
      set_irq(2'b11);

      do_start();
      wr_byte(8'hE6, 1'b0, "R2 wrong address no ack");
      wr_byte(8'h00, 1'b0, "R2 ignored byte no ack");
      do_stop();
      chk("R2 ignored write no effect", {6'b0, ch_en}, 8'h03);

      do_start();
      wr_byte(8'hE2, 1'b1, "R2 write address ack");
      wr_byte(8'h01, 1'b1, "R3 data ack");
      exp_sel = 2'b01;
      do_start();
      wr_byte(8'hE3, 1'b1, "R2 repeated start address ack");
      rd_byte(1'b0, 8'h01, "R6 uncommitted selection readback");
      chk("R4 repeated start no commit", {6'b0, ch_en}, 8'h03);
      do_stop();
      chk("R4 commit after repeated start", {6'b0, ch_en}, 8'h01);

      do_start();
      wr_byte(8'hE2, 1'b1, "R2 write address ack");
      for (int i = 0; i < 4; i++) bit_out(1'b0);
      do_stop();
      chk("R11 partial byte ignored", {6'b0, ch_en}, 8'h01);
      read_status(8'h01, "R11 selection kept");

      do_start();
      wr_byte(8'hE2, 1'b1, "R2 write address ack");
      wr_byte(8'h00, 1'b1, "R3 data ack");
      exp_sel = 2'b00;
      do_stop();
      set_irq(2'b01);
      chk("R8 irq with channels off", {7'b0, irq_oe}, 8'h01);
      read_status(8'h20, "R6 channel 1 interrupt bit");
      set_irq(2'b11);

      do_start();
      wr_byte(8'hE2, 1'b1, "R2 write address ack");
      wr_byte(8'h02, 1'b1, "R5 data ack");
      exp_sel = 2'b10;
      do_stop();
      pulse_reset(1'b0);
      chk("R1 ch_en after pin reset", {6'b0, ch_en}, 8'h00);
      read_status(8'h00, "R1 selection cleared");

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule